// File: doc/BRIEF.md
# Serial ADC Responder Interface

This block plays the converter side of a three-wire serial link to a 10-bit, eight-input analog-to-digital converter. It runs on the system clock and treats the serial clock, the active-low select and the command line from the master as ordinary inputs. All three are synchronized, and the serial clock edges are detected from the synchronized samples. The block waits for a start bit, then reads the input-mode bit and a channel number. It latches the 10-bit value for that channel from a parallel input bank. After a short sampling gap and a zero null bit, it returns the value most significant bit first.

Use it as a stand-in for a real converter, so that a master controller can be exercised in hardware or in a system model. The decoded mode and channel are shown on status outputs. Two sticky flags record protocol faults: a select that is released before the tenth result bit has been sent, and a select that stays high for too short a time between transfers. The serial output has a separate enable, and the pad buffer must present high impedance whenever that enable is low.

Top module: `adc_link_responder`

## Requirements
- R1: After reset, `dout_oe`, `err_short`, `err_csh` and `chan_valid` are 0. Whenever the synchronized select is high, `dout_oe` is 0 on the next clock.
- R2: While select is low, the block ignores `din` values of 0 sampled on rising serial clock edges. The first 1 it samples is the start bit.
- R3: The bit that follows the start bit sets the mode. A value of 1 gives single-ended and drives `mode_single` to 1. A value of 0 gives differential and drives `mode_single` to 0.
- R4: The next three rising-edge samples form the channel number, most significant bit first. When the third has been taken, `chan_sel` shows the number and `chan_valid` goes to 1. Both hold until select rises.
- R5: The result is the bank slice `bank[ch*10 +: 10]` at the moment the channel field completes. Later changes to the bank do not alter the bits of that transfer.
- R6: `SAMPLE_FALLS` falling serial clock edges (default 1) follow the channel field while `dout_oe` stays 0. On the next falling edge the block sets `dout_oe` to 1 and drives a null bit of 0.
- R7: Each of the next ten falling edges drives the next result bit, most significant bit first. After the tenth, `dout_o` holds the least significant bit until select rises.
- R8: If select rises after a start bit and before the tenth result bit has been driven, `err_short` sets and stays set. A select pulse with no start bit does not set it.
- R9: A falling select after fewer than `MIN_CSH` system clocks of synchronized high time sets `err_csh`, which stays set. The first transfer after reset counts as satisfied.
- R10: A `flag_clr` pulse clears both error flags.
- R11: A select that rises at any point in a transfer returns the block to idle. The next transfer decodes and returns data correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master |
| csn_i | input | 1 | Active-low select from the master |
| din_i | input | 1 | Command bits from the master |
| bank_i | input | NCH*RES_W | Conversion values, channel n at [n*RES_W +: RES_W] |
| flag_clr | input | 1 | Clears both error flags |
| dout_o | output | 1 | Serial result bit |
| dout_oe | output | 1 | Output enable for the result pad |
| mode_single | output | 1 | Decoded mode, 1 for single-ended |
| chan_sel | output | CHW | Decoded channel number |
| chan_valid | output | 1 | Mode and channel are decoded for this transfer |
| err_short | output | 1 | Sticky flag for a transfer cut short |
| err_csh | output | 1 | Sticky flag for a select-high time that was too short |

## Verification
Four rules are checked on every cycle:
- the output enable drops while select is high;
- the first bit driven after the enable rises is a zero;
- the decoded channel, the mode and the latched result stay stable through a transfer;
- the select-timing flag is sticky, and the short-transfer flag only sets on a select release.

Only the bench scenarios can show the rest:
- the bit order and value of the returned word;
- how the start bit is found after leading zeros;
- that a bank change made after the channel is decoded is ignored;
- recovery after an aborted transfer, and detection of a select-high pulse that is too short.

// File: rtl/adc_link_responder.sv
module adc_link_responder #(
  parameter int RES_W        = 10,
  parameter int NCH          = 8,
  parameter int SAMPLE_FALLS = 1,
  parameter int MIN_CSH      = 14,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_i,
  input  logic                 csn_i,
  input  logic                 din_i,
  input  logic [NCH*RES_W-1:0] bank_i,
  input  logic                 flag_clr,
  output logic                 dout_o,
  output logic                 dout_oe,
  output logic                 mode_single,
  output logic [CHW-1:0]       chan_sel,
  output logic                 chan_valid,
  output logic                 err_short,
  output logic                 err_csh
);
  localparam int CCW = $clog2(CHW + 1);
  localparam int SFW = $clog2(SAMPLE_FALLS + 2);
  localparam int BCW = $clog2(RES_W + 1);
  localparam int CSW = $clog2(MIN_CSH + 1);

  typedef enum logic [2:0] {S_IDLE, S_MODE, S_CHAN, S_GAP, S_DATA, S_DONE} st_t;

  st_t              st;
  logic             sclk_m, sclk_s, sclk_d;
  logic             cs_m, cs_s, cs_d;
  logic             din_m, din_s;
  logic [CCW-1:0]   chan_cnt;
  logic [SFW-1:0]   gap_cnt;
  logic [BCW-1:0]   bit_cnt;
  logic [CSW-1:0]   csh_cnt;
  logic [RES_W-1:0] res_q, sh_q;
  logic [CHW-1:0]   nxt_ch;
  logic [RES_W-1:0] bank_a [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_bank
    assign bank_a[g] = bank_i[g*RES_W +: RES_W];
  end

  wire sck_rise = sclk_s & ~sclk_d;
  wire sck_fall = ~sclk_s & sclk_d;
  wire cs_rise  = cs_s & ~cs_d;
  wire cs_fall  = ~cs_s & cs_d;
  wire in_xfer  = (st == S_MODE) || (st == S_CHAN) || (st == S_GAP) || (st == S_DATA);

  assign nxt_ch = {chan_sel[CHW-2:0], din_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sclk_m, sclk_s, sclk_d} <= '0;
      {cs_m, cs_s, cs_d}       <= '1;
      {din_m, din_s}           <= '0;
    end else begin
      {sclk_m, sclk_s, sclk_d} <= {sclk_i, sclk_m, sclk_s};
      {cs_m, cs_s, cs_d}       <= {csn_i, cs_m, cs_s};
      {din_m, din_s}           <= {din_i, din_m};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csh_cnt   <= CSW'(MIN_CSH);
      err_csh   <= 1'b0;
      err_short <= 1'b0;
    end else begin
      if (!cs_s)
        csh_cnt <= '0;
      else if (csh_cnt != CSW'(MIN_CSH))
        csh_cnt <= csh_cnt + 1'b1;
      if (flag_clr) begin
        err_csh   <= 1'b0;
        err_short <= 1'b0;
      end
      if (cs_fall && (csh_cnt < CSW'(MIN_CSH)))
        err_csh <= 1'b1;
      if (cs_rise && in_xfer)
        err_short <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      dout_o      <= 1'b0;
      dout_oe     <= 1'b0;
      mode_single <= 1'b0;
      chan_sel    <= '0;
      chan_valid  <= 1'b0;
      chan_cnt    <= '0;
      gap_cnt     <= '0;
      bit_cnt     <= '0;
      res_q       <= '0;
      sh_q        <= '0;
    end else if (cs_s) begin
      st         <= S_IDLE;
      dout_oe    <= 1'b0;
      dout_o     <= 1'b0;
      chan_valid <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (sck_rise && din_s) st <= S_MODE;
        S_MODE: if (sck_rise) begin
          mode_single <= din_s;
          chan_cnt    <= '0;
          st          <= S_CHAN;
        end
        S_CHAN: if (sck_rise) begin
          chan_sel <= nxt_ch;
          chan_cnt <= chan_cnt + 1'b1;
          if (chan_cnt == CCW'(CHW - 1)) begin
            res_q      <= bank_a[nxt_ch];
            chan_valid <= 1'b1;
            gap_cnt    <= '0;
            st         <= S_GAP;
          end
        end
        S_GAP: if (sck_fall) begin
          if (gap_cnt == SFW'(SAMPLE_FALLS)) begin
            dout_oe <= 1'b1;
            dout_o  <= 1'b0;
            sh_q    <= res_q;
            bit_cnt <= '0;
            st      <= S_DATA;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_DATA: if (sck_fall) begin
          dout_o  <= sh_q[RES_W-1];
          sh_q    <= sh_q << 1;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BCW'(RES_W - 1)) st <= S_DONE;
        end
        S_DONE: ;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module adc_link_responder_chk #(
  parameter int RES_W = 10,
  parameter int CHW   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_s,
  input logic             cs_d,
  input logic             dout_o,
  input logic             dout_oe,
  input logic             flag_clr,
  input logic             err_short,
  input logic             err_csh,
  input logic             chan_valid,
  input logic             mode_single,
  input logic [CHW-1:0]   chan_sel,
  input logic [RES_W-1:0] res_q
);
  // R1
  cs_high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !dout_oe);
  // R6
  null_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> !dout_o);
  // R8
  short_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_short) |-> $past(cs_s && !cs_d));
  // R9
  csh_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_csh && !flag_clr) |=> err_csh);
  // R4
  decode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_valid && !cs_s) |=> ($stable(chan_sel) && $stable(mode_single)));
  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_valid && !cs_s) |=> $stable(res_q));
endmodule

bind adc_link_responder adc_link_responder_chk #(.RES_W(RES_W), .CHW(CHW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_d(cs_d), .dout_o(dout_o),
  .dout_oe(dout_oe), .flag_clr(flag_clr), .err_short(err_short),
  .err_csh(err_csh), .chan_valid(chan_valid), .mode_single(mode_single),
  .chan_sel(chan_sel), .res_q(res_q)
);

// File: tb/adc_link_responder_tb.sv
module adc_link_responder_tb_top;
  localparam int RES_W = 10;
  localparam int NCH   = 8;
  localparam int H     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, din = 1'b0, clr = 1'b0;
  logic [NCH*RES_W-1:0] bank = '0;
  logic dout, oe, msing, cval, e_short, e_csh;
  logic [2:0] csel;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adc_link_responder dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .din_i(din),
    .bank_i(bank), .flag_clr(clr), .dout_o(dout), .dout_oe(oe),
    .mode_single(msing), .chan_sel(csel), .chan_valid(cval),
    .err_short(e_short), .err_csh(e_csh)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck(input logic d, output logic q, output logic e);
    din = d;
    wait_n(H);
    q = dout; e = oe;
    sclk = 1'b1;
    wait_n(H);
    sclk = 1'b0;
  endtask

  task automatic cs_up(input int hold);
    wait_n(H);
    csn = 1'b1;
    wait_n(hold);
  endtask

  // Full transfer; returns the ten result bits.
  task automatic xfer(input int zeros, input logic md, input logic [2:0] ch,
                      input bit swap_bank, output logic [RES_W-1:0] word,
                      output logic null_b, output logic gap_oe);
    logic q, e;
    csn = 1'b0;
    wait_n(H);
    for (int i = 0; i < zeros; i++) sck(1'b0, q, e);
    sck(1'b1, q, e);
    sck(md, q, e);
    for (int i = 2; i >= 0; i--) sck(ch[i], q, e);
    wait_n(2);
    chk("R3 mode", msing, md);
    chk("R4 channel", csel, ch);
    chk("R4 valid", cval, 1);
    if (swap_bank) bank[ch*RES_W +: RES_W] = ~bank[ch*RES_W +: RES_W];
    sck(1'b0, q, gap_oe);
    sck(1'b0, null_b, e);
    chk("R6 null enable", e, 1);
    for (int i = RES_W - 1; i >= 0; i--) begin
      sck(1'b1, q, e);
      word[i] = q;
    end
  endtask

  task automatic t_reset;
    chk("R1 oe", oe, 0);
    chk("R1 short", e_short, 0);
    chk("R1 csh", e_csh, 0);
    chk("R1 valid", cval, 0);
  endtask

  task automatic t_single;
    logic [RES_W-1:0] w; logic nb, go, q, e;
    xfer(3, 1'b1, 3'd5, 0, w, nb, go);
    chk("R6 gap oe", go, 0);
    chk("R6 null", nb, 0);
    chk("R2 R7 word ch5", w, 10'h2D3);
    sck(1'b0, q, e);
    chk("R7 hold lsb", q, 1);
    cs_up(40);
    chk("R1 oe off", oe, 0);
    chk("R8 no short", e_short, 0);
    chk("R9 no csh", e_csh, 0);
  endtask

  task automatic t_diff;
    logic [RES_W-1:0] w; logic nb, go;
    xfer(0, 1'b0, 3'd2, 0, w, nb, go);
    chk("R7 word ch2", w, 10'h2AA);
    cs_up(40);
    chk("R1 valid clear", cval, 0);
  endtask

  task automatic t_latch;
    logic [RES_W-1:0] w; logic nb, go;
    xfer(1, 1'b1, 3'd7, 1, w, nb, go);
    chk("R5 latched word", w, 10'h3FF);
    cs_up(40);
    chk("R5 bank swapped", bank[7*RES_W +: RES_W], 10'h000);
  endtask

  task automatic t_abort;
    logic [RES_W-1:0] w; logic nb, go, q, e;
    csn = 1'b0;
    wait_n(H);
    sck(1'b1, q, e);
    sck(1'b1, q, e);
    sck(1'b1, q, e);
    cs_up(40);
    chk("R8 short set", e_short, 1);
    chk("R1 oe idle", oe, 0);
    xfer(2, 1'b1, 3'd1, 0, w, nb, go);
    chk("R11 clean restart", w, 10'h001);
    cs_up(40);
    chk("R8 still set", e_short, 1);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    wait_n(2);
    chk("R10 clear short", e_short, 0);
    csn = 1'b0;
    wait_n(20);
    cs_up(40);
    chk("R8 no start no flag", e_short, 0);
  endtask

  task automatic t_csh;
    logic [RES_W-1:0] w; logic nb, go;
    csn = 1'b0;
    wait_n(20);
    csn = 1'b1;
    wait_n(3);
    csn = 1'b0;
    wait_n(6);
    chk("R9 csh set", e_csh, 1);
    csn = 1'b1;
    wait_n(40);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    wait_n(2);
    chk("R10 clear csh", e_csh, 0);
    xfer(0, 1'b0, 3'd6, 0, w, nb, go);
    chk("R9 ok gap word", w, 10'h155);
    chk("R9 long gap no flag", e_csh, 0);
    cs_up(40);
  endtask

  initial begin
    bank[5*RES_W +: RES_W] = 10'h2D3;
    bank[2*RES_W +: RES_W] = 10'h2AA;
    bank[7*RES_W +: RES_W] = 10'h3FF;
    bank[1*RES_W +: RES_W] = 10'h001;
    bank[6*RES_W +: RES_W] = 10'h155;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    t_reset;
    t_single;
    t_diff;
    t_latch;
    t_abort;
    t_csh;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule